// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver with Address Filtering

This block receives asynchronous serial frames that carry an extra flag bit after the data byte. That flag marks a frame as an address (station ID) rather than payload. Several stations share one line. Each station sets an ID-wait control bit, and frames with the flag clear are then thrown away without trace. The first frame with the flag set is always delivered, and that frame clears the ID-wait bit. Software then compares the delivered byte against its own station ID. It either keeps receiving payload or arms ID-wait again.

The line is brought into the clock domain through a two-stage synchronizer and oversampled at 16 samples per bit. The oversampling is paced by an external baud tick. A start bit counts as valid only if the line is still low at its mid-point, and every later bit is sampled at its centre. Three registers are reached through a simple address/write/read port:

- A data register holds the received byte.
- A status register holds the flags and the synchronized line level.
- A control register holds the ID-wait bit.

An overrun or framing error halts reception until software clears it. The live line level lets software tell a break condition from an ordinary framing error.

Top module: `mp_serial_rx`

## Requirements
- R1: A frame is, in line order, start bit 0, eight data bits with the least significant bit first, a flag bit, then a stop bit 1. When a frame is accepted and the receive-full flag (status bit 0) is clear, the data register (address 0) takes the byte and receive-full becomes 1.
- R2: Writing control register (address 2) bit 0 with 1 sets ID-wait. While ID-wait is 1, a frame whose flag bit is 0 changes neither the data register nor any status flag, and ID-wait stays 1.
- R3: A frame whose flag bit is 1 is accepted whatever the ID-wait value, and it clears ID-wait to 0.
- R4: With ID-wait at 0, frames are accepted whatever their flag bit. Status bit 4 holds the flag bit of the byte last stored in the data register.
- R5: If an accepted frame completes while receive-full is 1, the overrun flag (status bit 1) becomes 1 and the data register keeps its old byte.
- R6: An accepted frame whose stop bit is sampled as 0 sets the framing-error flag (status bit 2), and its byte is still stored when receive-full was clear.
- R7: While the overrun or framing-error flag is 1, no frame is received and the line is ignored. Reception resumes once both flags are 0.
- R8: Status bit 3 reads the synchronized level of the serial input at all times.
- R9: Writing 1 to status bits 0, 1 or 2 clears that flag, and writing 0 leaves it unchanged. A clear of receive-full in the same cycle as a frame completes takes effect first: the frame is stored, receive-full stays 1 and no overrun is raised.
- R10: After reset the data register is 0, ID-wait is 0, and the status register reads only the line level in bit 3.
- R11: A low pulse that has ended before the middle of the start bit does not begin a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One pulse per oversample period (16 per bit) |
| rxd | input | 1 | Asynchronous serial input, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |

## Verification
The collision that matters is a frame completing in the same clock cycle in which software clears receive-full. A wrong priority here either loses the new byte or raises a false overrun. The bench first leaves an older byte pending. It then sends a second frame and, over a sweep of write cycles around the known stop-bit sampling edge, issues the receive-full clear. Clears up to and including the completion cycle must produce the new byte with no overrun. Later clears must produce the old byte, overrun set and receive-full cleared. The switch must happen at exactly the computed cycle.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STS  = 2'd1;
    localparam logic [1:0] ADDR_CTL  = 2'd2;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              mp;
        logic              stop_ok;
    } frame_t;

    typedef struct packed {
        logic mp;
        logic fer;
        logic ovr;
        logic full;
    } flags_t;

    function automatic logic frame_wanted(input logic id_wait, input logic mp);
        return !(id_wait && !mp);
    endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mprx_deframer.sv
module mprx_deframer
    import mprx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rx,
    input  logic   enable,
    output logic   idle,
    output logic   done,
    output frame_t frame
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned NBITS = BYTE_W + 1;
    localparam int unsigned IDX_W = $clog2(NBITS + 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W:0]   shreg;
    logic              at_centre;

    assign at_centre = tick && (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (tick && enable && !rx) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == HALF_C) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= rx ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (at_centre) begin
                        cnt   <= '0;
                        shreg <= {rx, shreg[BYTE_W:1]};
                        if (idx == IDX_LAST) begin
                            state <= RX_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_centre) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign idle          = (state == RX_IDLE);
    assign done          = (state == RX_STOP) && at_centre;
    assign frame.data    = shreg[BYTE_W-1:0];
    assign frame.mp      = shreg[BYTE_W];
    assign frame.stop_ok = rx;
endmodule

// File: rtl/mprx_regs.sv
module mprx_regs
    import mprx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_done,
    input  frame_t            frame,
    input  logic              line,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [BYTE_W-1:0] rx_data,
    output flags_t            flags,
    output logic              id_wait,
    output logic              blocked
);
    logic       wr_sts;
    logic       wr_ctl;
    logic [2:0] clr;
    logic       take;
    logic       full_eff;
    logic       unused_wbits;

    assign wr_sts       = reg_wr && (reg_addr == ADDR_STS);
    assign wr_ctl       = reg_wr && (reg_addr == ADDR_CTL);
    assign clr          = wr_sts ? reg_wdata[2:0] : 3'b000;
    assign take         = frm_done && frame_wanted(id_wait, frame.mp);
    assign full_eff     = flags.full && !clr[0];
    assign unused_wbits = ^reg_wdata[7:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            flags   <= '0;
            id_wait <= 1'b0;
        end else begin
            flags.full <= full_eff;
            flags.ovr  <= flags.ovr && !clr[1];
            flags.fer  <= flags.fer && !clr[2];
            if (wr_ctl) begin
                id_wait <= reg_wdata[0];
            end
            if (take) begin
                if (frame.mp) begin
                    id_wait <= 1'b0;
                end
                if (!frame.stop_ok) begin
                    flags.fer <= 1'b1;
                end
                if (full_eff) begin
                    flags.ovr <= 1'b1;
                end else begin
                    rx_data    <= frame.data;
                    flags.full <= 1'b1;
                    flags.mp   <= frame.mp;
                end
            end
        end
    end

    assign blocked = flags.ovr || flags.fer;

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = rx_data;
            ADDR_STS:  reg_rdata = {3'b000, flags.mp, line, flags.fer, flags.ovr, flags.full};
            ADDR_CTL:  reg_rdata = {7'b0000000, id_wait};
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx
    import mprx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    logic              rx_s;
    logic              rx_idle;
    logic              frm_done;
    frame_t            frm;
    logic [BYTE_W-1:0] rx_data;
    flags_t            flags;
    logic              id_wait;
    logic              blocked;

    mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rx_s)
    );

    mprx_deframer #(.OSR(OSR)) u_deframer (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .rx     (rx_s),
        .enable (!blocked),
        .idle   (rx_idle),
        .done   (frm_done),
        .frame  (frm)
    );

    mprx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .frm_done  (frm_done),
        .frame     (frm),
        .line      (rx_s),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_data   (rx_data),
        .flags     (flags),
        .id_wait   (id_wait),
        .blocked   (blocked)
    );
endmodule

// File: rtl/mprx_checker.sv
module mprx_checker
    import mprx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              frm_done,
    input logic              frm_mp,
    input logic              frm_stop,
    input logic              rx_idle,
    input flags_t            flags,
    input logic              id_wait,
    input logic [BYTE_W-1:0] rx_data
);
    logic wanted;
    assign wanted = frame_wanted(id_wait, frm_mp);

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> !frm_done);

    p_full_set_r1: assert property (@(posedge clk) disable iff (rst)
        (frm_done && wanted) |=> flags.full);

    p_drop_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (frm_done && id_wait && !frm_mp && !reg_wr) |=> ($stable(rx_data) && $stable(flags) && id_wait));

    p_idwait_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm_mp) |=> !id_wait);

    p_overrun_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (frm_done && wanted && flags.full && !reg_wr) |=> (flags.ovr && $stable(rx_data)));

    p_framing_r6: assert property (@(posedge clk) disable iff (rst)
        (frm_done && wanted && !frm_stop) |=> flags.fer);

    p_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (flags.ovr || flags.fer) |-> (rx_idle && !frm_done));
endmodule

bind mp_serial_rx mprx_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .frm_done (frm_done),
    .frm_mp   (frm.mp),
    .frm_stop (frm.stop_ok),
    .rx_idle  (rx_idle),
    .flags    (flags),
    .id_wait  (id_wait),
    .rx_data  (rx_data)
);

// File: tb/test_mp_serial_rx.sv
module test_mp_serial_rx;
    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick;
    logic       rxd;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mp_serial_rx i_mp_serial_rx (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .rxd       (rxd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic mp, input logic stop_v, input bit hold_low);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16) @(negedge clk);
        end
        rxd = mp;
        repeat (16) @(negedge clk);
        rxd = stop_v;
        repeat (16) @(negedge clk);
        rxd = hold_low ? 1'b0 : 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; baud_tick = 1'b1;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R10 reset state, R8 line high
        expect_reg(2'd0, 8'h00, "R10 data");
        expect_reg(2'd1, 8'h08, "R10/R8 status");
        expect_reg(2'd2, 8'h00, "R10 ctrl");

        // R1/R4 sweep of every byte, flag bit varied
        for (int b = 0; b < 256; b++) begin
            logic m;
            m = b[0] ^ b[7];
            send_frame(b[7:0], m, 1'b1, 0);
            expect_reg(2'd0, b[7:0], "R1 data");
            expect_reg(2'd1, {3'b000, m, 4'b1001}, "R4 status");
            wr(2'd1, 8'h01);
        end
        expect_reg(2'd1, 8'h08, "R9 W1C full");

        // R11 short low pulse
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        expect_reg(2'd1, 8'h08, "R11 glitch ignored");

        // R2 ID-wait drops flag-0 frames
        wr(2'd2, 8'h01);
        expect_reg(2'd2, 8'h01, "R2 ctrl set");
        send_frame(8'h5A, 1'b0, 1'b1, 0);
        expect_reg(2'd0, 8'hFF, "R2 data kept");
        expect_reg(2'd1, 8'h08, "R2 flags kept");
        expect_reg(2'd2, 8'h01, "R2 idwait kept");
        // R2 with a framing error in the dropped frame
        send_frame(8'h11, 1'b0, 1'b0, 0);
        expect_reg(2'd1, 8'h08, "R2 bad stop dropped");

        // R3 flag-1 frame accepted, ID-wait cleared
        send_frame(8'h42, 1'b1, 1'b1, 0);
        expect_reg(2'd0, 8'h42, "R3 data");
        expect_reg(2'd1, 8'h19, "R3 status");
        expect_reg(2'd2, 8'h00, "R3 idwait cleared");

        // R2 drop while full: no overrun
        wr(2'd2, 8'h01);
        send_frame(8'h77, 1'b0, 1'b1, 0);
        expect_reg(2'd1, 8'h19, "R2 no overrun on drop");
        expect_reg(2'd0, 8'h42, "R2 data kept full");
        // R3 ID frame while full: overrun, ID-wait cleared anyway
        send_frame(8'h99, 1'b1, 1'b1, 0);
        expect_reg(2'd2, 8'h00, "R3 idwait cleared on overrun");
        expect_reg(2'd1, 8'h1B, "R5 overrun on ID");
        wr(2'd1, 8'h07);

        // R4 payload accepted after ID
        send_frame(8'hC3, 1'b0, 1'b1, 0);
        expect_reg(2'd0, 8'hC3, "R4 payload data");
        expect_reg(2'd1, 8'h09, "R4 payload status");

        // R5 overrun keeps old byte; R7 blocked
        send_frame(8'h3D, 1'b0, 1'b1, 0);
        expect_reg(2'd0, 8'hC3, "R5 data kept");
        expect_reg(2'd1, 8'h0B, "R5 status");
        wr(2'd1, 8'h01);
        send_frame(8'hE1, 1'b0, 1'b1, 0);
        expect_reg(2'd0, 8'hC3, "R7 blocked data");
        expect_reg(2'd1, 8'h0A, "R7 blocked status");
        wr(2'd1, 8'h02);
        send_frame(8'hE1, 1'b0, 1'b1, 0);
        expect_reg(2'd0, 8'hE1, "R7 resumed data");
        expect_reg(2'd1, 8'h09, "R7 resumed status");
        wr(2'd1, 8'h01);

        // R6 break: stop low, line held low
        send_frame(8'h81, 1'b0, 1'b0, 1);
        expect_reg(2'd0, 8'h81, "R6 data stored");
        expect_reg(2'd1, 8'h05, "R6/R8 fer, line low");
        repeat (300) @(negedge clk);
        expect_reg(2'd1, 8'h05, "R7 break ignored");
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        expect_reg(2'd1, 8'h0D, "R8 line high");
        wr(2'd1, 8'h04);
        expect_reg(2'd1, 8'h09, "R9 W1C fer only");
        wr(2'd1, 8'h00);
        expect_reg(2'd1, 8'h09, "R9 write zero no effect");
        wr(2'd1, 8'h01);
        send_frame(8'h6E, 1'b1, 1'b1, 0);
        expect_reg(2'd0, 8'h6E, "R6 recovery data");

        // R9 clear vs completion sweep; completion edge is 171
        for (int n = 165; n <= 177; n++) begin
            wr(2'd1, 8'h07);
            send_frame(8'hA5, 1'b0, 1'b1, 0);
            fork
                send_frame(8'h3C, 1'b0, 1'b1, 0);
                begin
                    repeat (n - 1) @(posedge clk);
                    @(negedge clk);
                    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
                    @(negedge clk);
                    reg_wr = 1'b0;
                end
            join
            expect_reg(2'd0, (n <= 171) ? 8'h3C : 8'hA5, "R9 collision data");
            expect_reg(2'd1, (n <= 171) ? 8'h09 : 8'h0A, "R9 collision status");
        end

        summary();
    end
endmodule